// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation converter. It sits on a small byte-wide register bus. Software picks a channel and a reference, sets a clock divide code, and starts a conversion. The controller then divides the system clock into a conversion clock. Over 13 ticks of that clock it samples the input, runs an MSB-first binary search, and transfers the 10-bit answer into a 16-bit result pair.

During the search the controller drives a trial code onto a DAC and reads back one comparator bit. A bit of the trial code is kept when the comparator reports that the input is at or above the trial level. When the conversion ends, a sticky completion flag is raised. This flag drives an interrupt through an enable mask. Software reads the result right- or left-justified, depending on a format bit in the select register.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, all four byte registers read 0x00, and `irq`, `chan_sel` and `ref_sel` are 0. The register addresses are: 0 for select, 1 for control, 2 for result low byte, 3 for result high byte.
- R2: A conversion sets the completion flag exactly 13·N system clock edges after the edge that accepted the start. N is set by control bits 2:0: codes 0 and 1 give 2, code 2 gives 4, code 3 gives 8, code 4 gives 16, code 5 gives 32, code 6 gives 64 and code 7 gives 128.
- R3: The stored result equals the input code that the comparator models. The comparator reports high when the input is at or above `dac_code`. The result does not change outside a completed conversion.
- R4: A start (control bit 6) only takes effect when the same write also sets enable (bit 7). A control write that clears enable aborts a running conversion: no flag is set and the result is unchanged.
- R5: Control bit 6 reads 1 while a conversion is busy and clears on its own at completion. A start written while busy does not restart the conversion or move its completion.
- R6: The completion flag (control bit 4) sets at completion. Writing 1 to bit 4 clears it, and writing 0 leaves it set. If a clear and a completion fall on the same edge, the flag ends up set.
- R7: `irq` is high exactly when the completion flag and the interrupt enable (control bit 3) are both 1.
- R8: With select bit 5 at 0, result bits 9:8 appear in bits 1:0 of the high byte, result bits 7:0 fill the low byte, and all other bits read 0.
- R9: With select bit 5 at 1, result bits 9:2 fill the high byte, result bits 1:0 appear in bits 7:6 of the low byte, and all other bits read 0. The format follows bit 5 at read time.
- R10: The select register reads back what was written, except that bit 4 always reads 0. At start, the channel (bits 3:0) and the reference (bits 7:6) are latched onto `chan_sel` and `ref_sel`. They are held there even if the select register is rewritten while the conversion is busy.
- R11: Control bit 5 is stored and read back, and has no effect on conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_hi | input | 1 | Comparator: input at or above the trial level |
| dac_code | output | 10 | Trial code for the DAC |
| sampling | output | 1 | High during the sampling tick window |
| chan_sel | output | 4 | Latched channel for the analog multiplexer |
| ref_sel | output | 2 | Latched reference selection |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on one clock edge: a software write of 1 to the completion flag, and the converter's own completion. The bench provokes this with divide code 0. It counts 26 edges from the accepted start and places the flag-clearing control write exactly on the completing edge. The check is that the flag reads set afterwards. A second collision is handled the same way: a start write issued while the engine is busy must leave the completion edge where the reference model predicts it. The model tracks every cycle and is compared to the register readback, `irq`, `chan_sel` and `ref_sel` on each clock.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        REG_SEL = 2'd0,
        REG_CTL = 2'd1,
        REG_RLO = 2'd2,
        REG_RHI = 2'd3
    } reg_addr_e;

    // control byte bit positions
    localparam int CTL_EN  = 7;
    localparam int CTL_GO  = 6;
    localparam int CTL_AT  = 5;
    localparam int CTL_FLG = 4;
    localparam int CTL_IE  = 3;

    // select byte layout
    localparam int SEL_REF_LSB = 6;
    localparam int SEL_LADJ    = 5;
    localparam logic [BUS_W-1:0] SEL_MASK = 8'hEF;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t        st_q, st_d;
    logic [CNT_W:0] lim;

    always_comb begin
        if (sel <= SEL_W'(1)) lim = (CNT_W+1)'(2);
        else                  lim = (CNT_W+1)'(1) << sel;
        tick = run && ({1'b0, st_q.cnt} == (lim - 1'b1));
        st_d = st_q;
        if (!run || tick) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic             sampling,
    output logic             res_load,
    output logic [RES_W-1:0] res_value,
    output logic             done
);
    localparam int STEPS     = RES_W + 3;
    localparam int STEP_W    = $clog2(STEPS);
    localparam int XFER_STEP = RES_W + 1;
    localparam int DONE_STEP = RES_W + 2;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [RES_W-1:0]  dac;
    } eng_t;

    eng_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        res_load = 1'b0;
        done     = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            if (st_q.step == '0) st_d.dac = '0;
            for (int b = 0; b < RES_W; b++) begin
                // decide bit b one tick after it was trialled
                if (int'(st_q.step) == RES_W - b && !cmp_hi) st_d.dac[b] = 1'b0;
                if (int'(st_q.step) == RES_W - 1 - b)        st_d.dac[b] = 1'b1;
            end
            if (int'(st_q.step) == XFER_STEP) res_load = 1'b1;
            if (int'(st_q.step) == DONE_STEP) begin
                done       = 1'b1;
                st_d.step  = '0;
            end else begin
                st_d.step  = st_q.step + 1'b1;
            end
        end
    end

    assign dac_code  = st_q.dac;
    assign res_value = st_q.dac;
    assign sampling  = run && (st_q.step == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(st_q.step) <= DONE_STEP)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.step == '0)); // R4
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int SEL_W = 3,
    parameter int CH_W  = 4,
    parameter int REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic             sampling,
    output logic [CH_W-1:0]  chan_sel,
    output logic [REF_W-1:0] ref_sel,
    output logic             irq
);
    localparam int PAIR_W = 2 * BUS_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    typedef struct packed {
        logic [BUS_W-1:0] selr;
        logic             en;
        logic             ate;
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] presc;
        logic             busy;
        logic [CH_W-1:0]  lat_ch;
        logic [REF_W-1:0] lat_ref;
        logic [RES_W-1:0] result;
    } ctl_t;

    ctl_t st_q, st_d;

    logic             tick, eng_load, eng_done;
    logic [RES_W-1:0] eng_res;
    logic             ctl_wr, abort, go;
    logic [PAIR_W-1:0] pair;

    sar_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.busy),
        .sel  (st_q.presc),
        .tick (tick)
    );

    sar_engine #(.RES_W(RES_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.busy),
        .tick     (tick),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .sampling (sampling),
        .res_load (eng_load),
        .res_value(eng_res),
        .done     (eng_done)
    );

    always_comb begin
        st_d   = st_q;
        ctl_wr = bus_wr && (reg_addr_e'(bus_addr) == REG_CTL);
        abort  = ctl_wr && !bus_wdata[CTL_EN];
        go     = ctl_wr && bus_wdata[CTL_EN] && bus_wdata[CTL_GO] && !st_q.busy;

        if (bus_wr && (reg_addr_e'(bus_addr) == REG_SEL))
            st_d.selr = bus_wdata & SEL_MASK;

        if (ctl_wr) begin
            st_d.en    = bus_wdata[CTL_EN];
            st_d.ate   = bus_wdata[CTL_AT];
            st_d.ie    = bus_wdata[CTL_IE];
            st_d.presc = bus_wdata[SEL_W-1:0];
            if (bus_wdata[CTL_FLG]) st_d.flag = 1'b0;
        end

        if (eng_load && !abort) st_d.result = eng_res;

        if (abort) begin
            st_d.busy = 1'b0;
        end else if (go) begin
            st_d.busy    = 1'b1;
            st_d.lat_ch  = st_q.selr[CH_W-1:0];
            st_d.lat_ref = st_q.selr[SEL_REF_LSB +: REF_W];
        end else if (eng_done) begin
            st_d.busy = 1'b0;
        end

        // completion wins over a same-edge clear
        if (eng_done && !abort) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.selr[SEL_LADJ]) pair = {st_q.result, {PAD_W{1'b0}}};
        else                     pair = {{PAD_W{1'b0}}, st_q.result};
        unique case (reg_addr_e'(bus_addr))
            REG_SEL: bus_rdata = st_q.selr;
            REG_CTL: bus_rdata = {st_q.en, st_q.busy, st_q.ate, st_q.flag,
                                  st_q.ie, st_q.presc};
            REG_RLO: bus_rdata = pair[BUS_W-1:0];
            REG_RHI: bus_rdata = pair[PAIR_W-1:BUS_W];
            default: bus_rdata = '0;
        endcase
    end

    assign chan_sel = st_q.lat_ch;
    assign ref_sel  = st_q.lat_ref;
    assign irq      = st_q.flag & st_q.ie;

    AST_EN_GATES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> !st_q.busy); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(ctl_wr && bus_wdata[CTL_FLG])) |=> st_q.flag); // R6
    AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(eng_done)); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> ($stable(st_q.lat_ch) && $stable(st_q.lat_ref))); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_load |=> $stable(st_q.result)); // R3
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ie |-> !irq); // R7
endmodule

// File: tb/sar_adc_ctrl_bench.sv
`timescale 1ns/1ps
module sar_adc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd1;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_hi;
    logic [9:0] dac_code;
    logic       sampling;
    logic [3:0] chan_sel;
    logic [1:0] ref_sel;
    logic       irq;
    logic [9:0] vin = 10'd0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    int m_sel = 0, m_en = 0, m_busy = 0, m_ate = 0, m_flag = 0, m_ie = 0, m_presc = 0;
    int m_rem = 0, m_res = 0, m_lch = 0, m_lref = 0;

    always #2 clk = ~clk;

    assign cmp_hi = (vin >= dac_code);

    sar_adc_ctrl u_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .sampling(sampling), .chan_sel(chan_sel),
        .ref_sel(ref_sel), .irq(irq)
    );

    function automatic int divn(int s);
        case (s)
            0, 1: return 2;
            2: return 4;
            3: return 8;
            4: return 16;
            5: return 32;
            6: return 64;
            default: return 128;
        endcase
    endfunction

    function automatic int mread(int a);
        case (a)
            0: return m_sel;
            1: return m_en*128 + m_busy*64 + m_ate*32 + m_flag*16 + m_ie*8 + m_presc;
            2: return ((m_sel / 32) % 2 == 1) ? (m_res % 4) * 64 : m_res % 256;
            default: return ((m_sel / 32) % 2 == 1) ? m_res / 4 : m_res / 256;
        endcase
    endfunction

    task automatic model_edge();
        int was_busy = m_busy;
        int a = int'(bus_addr);
        int d = int'(bus_wdata);
        bit abrt = bus_wr && a == 1 && d < 128;
        bit fin = 0;
        if (m_busy != 0 && !abrt) begin
            m_rem--;
            if (m_rem == divn(m_presc)) m_res = int'(vin);
            if (m_rem == 0) begin m_busy = 0; fin = 1; end
        end
        if (bus_wr && a == 0) m_sel = d & 8'hEF;
        if (bus_wr && a == 1) begin
            m_en = d / 128; m_ate = (d / 32) % 2; m_ie = (d / 8) % 2; m_presc = d % 8;
            if ((d / 16) % 2 == 1) m_flag = 0;
            if (abrt) begin m_busy = 0; m_rem = 0; end
            else if ((d / 64) % 2 == 1 && was_busy == 0) begin
                m_busy = 1; m_rem = 13 * divn(m_presc);
                m_lch = m_sel % 16; m_lref = m_sel / 64;
            end
        end
        if (fin) m_flag = 1;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        int e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e = mread(int'(bus_addr));
        chk(int'(bus_rdata) == e, (bus_addr == 1) ? "R6 per-cycle control" :
            (bus_addr == 0) ? "R10 per-cycle select" : "R8 per-cycle result", int'(bus_rdata), e);
        chk(int'(irq) == (m_flag & m_ie), "R7 per-cycle irq", int'(irq), m_flag & m_ie);
        chk(int'(chan_sel) == m_lch && int'(ref_sel) == m_lref, "R10 per-cycle latch",
            int'({ref_sel, chan_sel}), m_lref * 16 + m_lch);
    endtask

    task automatic wr(int a, int d);
        bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
        step();
        bus_wr = 1'b0; bus_addr = 2'd1;
    endtask

    task automatic rd(int a, int exp, string tag);
        bus_addr = 2'(a);
        #1;
        chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
        bus_addr = 2'd1;
        #0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // full conversion; checks the completion edge count (R2)
    task automatic conv(int s, int v, int ie);
        int k = 0;
        vin = 10'(v);
        wr(1, 8'h90 | s);
        wr(1, 8'hC0 | (ie * 8) | s);
        while (bus_rdata[4] == 1'b0 && k < 3000) begin step(); k++; end
        chk(k == 13 * divn(s), "R2 conversion length", k, 13 * divn(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) rd(a, 0, "R1 reset register");
        chk(irq == 1'b0 && chan_sel == 4'd0 && ref_sel == 2'd0, "R1 reset outputs", int'(irq), 0);
        idle(2);

        // R10 select readback with bit 4 masked
        wr(0, 8'hFF);
        rd(0, 8'hEF, "R10 select readback");
        wr(0, 8'h45);

        // R4 start without enable is ignored
        wr(1, 8'h40);
        idle(40);
        rd(1, 8'h00, "R4 start without enable");

        // R3 R8 R7 basic conversion, divide code 0
        conv(0, 10'h2A5, 1);
        rd(2, 8'hA5, "R8 right low byte");
        rd(3, 8'h02, "R8 right high byte");
        chk(irq == 1'b1, "R7 irq with enable", int'(irq), 1);
        chk(chan_sel == 4'd5 && ref_sel == 2'd1, "R10 latched channel", int'(chan_sel), 5);

        // R9 left justification follows the select bit at read time
        wr(0, 8'h25);
        rd(3, 8'hA9, "R9 left high byte");
        rd(2, 8'h40, "R9 left low byte");

        // R6 writing 0 keeps flag, writing 1 clears it
        wr(1, 8'h88);
        rd(1, 8'h98, "R6 write zero keeps flag");
        wr(1, 8'h98);
        rd(1, 8'h88, "R6 write one clears flag");

        // R2 R3 sweep of every divide code with varied inputs
        for (int s = 0; s < 8; s++) begin
            int v = (s * 147 + 31) % 1024;
            conv(s, v, s % 2);
            rd(3, v / 4, "R3 result high byte");
            rd(2, (v % 4) * 64, "R3 result low byte");
        end
        conv(1, 0, 1);
        rd(3, 0, "R3 zero input");
        conv(3, 1023, 0);
        rd(3, 8'hFF, "R3 full scale high");
        rd(2, 8'hC0, "R3 full scale low");
        chk(irq == 1'b0, "R7 irq masked", int'(irq), 0);

        // R11 auto-trigger bit stored, no effect
        wr(1, 8'hB0 | 8'h02);
        rd(1, 8'hA2, "R11 bit stored");
        idle(60);
        rd(1, 8'hA2, "R11 no conversion");

        // R5 R10 restart ignored while busy, latch held
        vin = 10'h155;
        wr(0, 8'hC3);
        begin
            int k = 0;
            wr(1, 8'hC2); 
            chk(ref_sel == 2'd3 && chan_sel == 4'd3, "R10 reference latched", int'(ref_sel), 3);
            for (int i = 0; i < 9; i++) begin step(); k++; end
            rd(1, 8'hC2, "R5 busy reads start bit");
            wr(1, 8'hC2); k++;
            wr(0, 8'h09); k++;
            while (bus_rdata[4] == 1'b0 && k < 3000) begin step(); k++; end
            chk(k == 52, "R5 restart ignored", k, 52);
            rd(1, 8'h92, "R5 start bit self clears");
            chk(chan_sel == 4'd3, "R10 latch held during busy", int'(chan_sel), 3);
            rd(2, 8'h55, "R8 result after restart");
        end

        // R4 abort by clearing enable
        wr(1, 8'h90);
        vin = 10'h3FF;
        wr(1, 8'hC1);
        idle(20);
        wr(1, 8'h00);
        rd(1, 8'h00, "R4 abort clears busy");
        idle(100);
        rd(1, 8'h00, "R4 no flag after abort");
        rd(2, 8'h55, "R4 result unchanged");

        // R6 clear and completion on the same edge
        vin = 10'h0F0;
        wr(1, 8'hC0);
        idle(25);
        wr(1, 8'h90);
        rd(1, 8'h90, "R6 completion wins over clear");

        idle(4);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule